// File: doc/BRIEF.md
# Receive Buffer with Character Timeout

This block sits between a serial deserialiser and the host-side register file of a 16550-style UART. It holds received bytes in a 16-entry circular FIFO. When the FIFO is switched off it keeps a single holding byte instead. It tracks the data-ready, break and overrun conditions. It raises a trigger flag once the fill level reaches a programmable threshold. A character-timeout detector flags bytes that sit unread for four character times. The deserialiser delivers bytes and break events as one-cycle strobes. The host side delivers FIFO-control writes, receive-buffer read strobes and status-read strobes.

The character time is counted in ticks of an external bit-rate enable. The frame format comes from the low four bits of the line-control word. The interrupt arbiter downstream combines `trig_hit`, `tmo_pend`, `data_ready` and the error flags.

Top module: `rx_buffer`

## Requirements
- R1: After reset the FIFO is disabled, the trigger level is 1 byte, and the following outputs are all zero: `rd_data`, `data_ready`, `brk_flag`, `overrun`, `fifo_count`, `trig_hit` and `tmo_pend`.
- R2: A FIFO-control write latches the enable from bit 0 and the trigger select from bits 7:6, where 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. In FIFO mode `trig_hit` is high while `fifo_count` is at or above the selected level. In holding mode `trig_hit` follows `data_ready`.
- R3: A FIFO-control write flushes the receive side when bit 1 is set or when bit 0 differs from the current enable. A flush empties the FIFO and clears data-ready, break and the pending and running timeout. A byte, break or read arriving in the same cycle as the flush is ignored.
- R4: In FIFO mode, bytes leave in arrival order. `rd_data` shows the oldest byte, and a read strobe removes it. Reading an empty FIFO returns 0x00. Data-ready and break clear when a read leaves the FIFO empty.
- R5: In FIFO mode, a byte or break that arrives while the FIFO holds 16 entries is discarded and sets `overrun`, and the stored contents are unchanged. A read in the same cycle frees a slot first.
- R6: In holding mode, each arriving byte replaces the holding byte. `overrun` is set if data-ready was still set after any read in the same cycle. A read clears data-ready and break. `fifo_count` stays 0.
- R7: A break event stores a 0x00 byte and sets both break and data-ready. It takes precedence over a data byte in the same cycle.
- R8: A status-read strobe clears `overrun` and `brk_flag`. A new overrun or break in the same cycle wins.
- R9: In FIFO mode the timeout restarts on every arriving byte and on every read that leaves data behind. After four character times of bit ticks, `tmo_pend` sets if the FIFO is non-empty. Any read clears `tmo_pend`.
- R10: One character time in bit ticks is 1 + (fmt[1:0] + 5) + fmt[3] + (fmt[2] ? 2 : 1). The value of `lcr_fmt` is sampled when the timeout restarts.
- R11: A flush cancels a timeout that is still counting, so it never sets `tmo_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One pulse per serial bit time |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event strobe |
| fcr_we | input | 1 | FIFO-control write strobe |
| fcr_wdata | input | 8 | FIFO-control write value |
| rd_stb | input | 1 | Receive-buffer read strobe |
| stat_rd | input | 1 | Status read strobe (clears overrun and break) |
| lcr_fmt | input | 4 | Frame format: [1:0] data length, [2] two stop bits, [3] parity present |
| rd_data | output | 8 | Value returned by a read this cycle |
| data_ready | output | 1 | Data available |
| brk_flag | output | 1 | Break received |
| overrun | output | 1 | Byte lost |
| fifo_count | output | 5 | FIFO fill level |
| trig_hit | output | 1 | Trigger level reached |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The bench builds the block with its defaults: `DEPTH` = 16 and `TMO_CHARS` = 4. The bit tick pulses every second clock, so a full timeout takes at most 96 cycles. With these values the 14-byte trigger, the full-FIFO drop and every frame length from 7 to 12 bits are all reached within a few hundred cycles. A behavioural queue model is compared with every output on every clock. The comparison covers directed phases and a long stretch of random traffic, including random control writes.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int FC_EN     = 0;
  localparam int FC_RXRST  = 1;
  localparam int MAX_FRAME = 12;

  // trigger select code to byte count
  function automatic int trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // bits per character: start + data + optional parity + stop(s)
  function automatic int frame_bits(input logic [3:0] fmt);
    return 1 + (int'(fmt[1:0]) + 5) + int'(fmt[3]) + (fmt[2] ? 2 : 1);
  endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [7:0]    wdata,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop)  rp_q <= nxt(rp_q);
      if (push) wp_q <= nxt(wp_q);
      cnt_q <= cnt_q - CW'(pop) + CW'(push);
    end
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/rxbuf_timer.sv
module rxbuf_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cancel,
  input  logic          restart,
  input  logic [TW-1:0] load,
  output logic          expire
);
  logic          run_q;
  logic [TW-1:0] cnt_q;

  assign expire = run_q & tick & (cnt_q == TW'(1)) & ~restart & ~cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cancel) begin
      run_q <= 1'b0;
    end else if (restart) begin
      run_q <= 1'b1;
      cnt_q <= load;
    end else if (run_q && tick) begin
      if (cnt_q == TW'(1)) run_q <= 1'b0;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import rxbuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_break,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          rd_stb,
  input  logic          stat_rd,
  input  logic [3:0]    lcr_fmt,
  output logic [7:0]    rd_data,
  output logic          data_ready,
  output logic          brk_flag,
  output logic          overrun,
  output logic [CW-1:0] fifo_count,
  output logic          trig_hit,
  output logic          tmo_pend
);
  localparam int TW = $clog2(TMO_CHARS * MAX_FRAME + 1);

  logic          fifo_en_q, dr_q, brk_q, ovr_q, pend_q;
  logic [1:0]    lvl_q;
  logic [7:0]    hold_q;
  logic [7:0]    head;
  logic [CW-1:0] count, cnt_after_pop, cnt_next;
  logic          flush, live, rx_any, rd_ok, pop, push, drop;
  logic          left_data, clear_on_rd, hold_ovr, restart, expire;
  logic [7:0]    in_byte;
  logic [TW-1:0] tmo_load;
  logic          unused_fcr_bits;

  assign unused_fcr_bits = ^fcr_wdata[5:2];

  // event decode, named for the checker
  assign flush   = fcr_we & (fcr_wdata[FC_RXRST] | (fcr_wdata[FC_EN] ^ fifo_en_q));
  assign live    = ~flush;
  assign rx_any  = (rx_valid | rx_break) & live;
  assign rd_ok   = rd_stb & live;
  assign in_byte = rx_break ? 8'h00 : rx_byte;

  assign pop           = rd_ok & fifo_en_q & (count != '0);
  assign cnt_after_pop = count - CW'(pop);
  assign push          = rx_any & fifo_en_q & (cnt_after_pop < CW'(DEPTH));
  assign drop          = rx_any & fifo_en_q & ~push;
  assign cnt_next      = cnt_after_pop + CW'(push);

  assign left_data   = rd_ok & fifo_en_q & (cnt_after_pop != '0);
  assign clear_on_rd = rd_ok & (~fifo_en_q | (cnt_after_pop == '0));
  assign hold_ovr    = rx_any & ~fifo_en_q & dr_q & ~clear_on_rd;
  assign restart     = fifo_en_q & (rx_any | left_data);
  assign tmo_load    = TW'(TMO_CHARS * frame_bits(lcr_fmt));

  rxbuf_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (in_byte),
    .head  (head),
    .count (count)
  );

  rxbuf_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .cancel  (flush),
    .restart (restart),
    .load    (tmo_load),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      lvl_q     <= 2'd0;
      dr_q      <= 1'b0;
      brk_q     <= 1'b0;
      ovr_q     <= 1'b0;
      pend_q    <= 1'b0;
      hold_q    <= 8'h00;
    end else begin
      if (fcr_we) begin
        fifo_en_q <= fcr_wdata[FC_EN];
        lvl_q     <= fcr_wdata[7:6];
      end
      if (rx_any && !fifo_en_q) hold_q <= in_byte;

      if (flush)            dr_q <= 1'b0;
      else if (rx_any)      dr_q <= 1'b1;
      else if (clear_on_rd) dr_q <= 1'b0;

      if (flush)                   brk_q <= 1'b0;
      else if (rx_any && rx_break) brk_q <= 1'b1;
      else if (clear_on_rd)        brk_q <= 1'b0;
      else if (stat_rd)            brk_q <= 1'b0;

      if (drop || hold_ovr) ovr_q <= 1'b1;
      else if (stat_rd)     ovr_q <= 1'b0;

      if (flush)                           pend_q <= 1'b0;
      else if (expire && cnt_next != '0)   pend_q <= 1'b1;
      else if (rd_ok)                      pend_q <= 1'b0;
    end
  end

  assign rd_data    = fifo_en_q ? ((count != '0) ? head : 8'h00) : hold_q;
  assign data_ready = dr_q;
  assign brk_flag   = brk_q;
  assign overrun    = ovr_q;
  assign fifo_count = count;
  assign trig_hit   = fifo_en_q ? (int'(count) >= trig_bytes(lvl_q)) : dr_q;
  assign tmo_pend   = pend_q;
endmodule

// File: rtl/rxbuf_checks.sv
module rxbuf_checks #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          flush,
  input logic          drop,
  input logic          data_ready,
  input logic          brk_flag,
  input logic          overrun,
  input logic [CW-1:0] fifo_count,
  input logic          tmo_pend
);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  assert_drop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (int'(fifo_count) == DEPTH) && overrun);

  assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_count == '0) && !data_ready && !brk_flag && !tmo_pend);

  assert_ready_tracks_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |-> (data_ready == (fifo_count != '0)));

  assert_hold_mode_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (fifo_count == '0));

  assert_break_implies_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> data_ready);

  assert_pend_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> (fifo_count != '0));
endmodule

bind rx_buffer rxbuf_checks #(.DEPTH(DEPTH), .CW(CW)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en_q),
  .flush      (flush),
  .drop       (drop),
  .data_ready (data_ready),
  .brk_flag   (brk_flag),
  .overrun    (overrun),
  .fifo_count (fifo_count),
  .tmo_pend   (tmo_pend)
);

// File: tb/tb_rx_buffer.sv
`timescale 1ns/100ps
module tb_rx_buffer;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_valid = 1'b0, rx_break = 1'b0, fcr_we = 1'b0, rd_stb = 1'b0, stat_rd = 1'b0;
  logic [7:0] rx_byte = 8'h00, fcr_wdata = 8'h00;
  logic [3:0] lcr_fmt = 4'h3;
  logic [7:0] rd_data;
  logic       data_ready, brk_flag, overrun, trig_hit, tmo_pend;
  logic [4:0] fifo_count;

  int    checks = 0, errors = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;
  always @(negedge clk) baud_tick = ~baud_tick;

  rx_buffer #(.DEPTH(DEPTH), .TMO_CHARS(4)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_break(rx_break), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .rd_stb(rd_stb), .stat_rd(stat_rd), .lcr_fmt(lcr_fmt), .rd_data(rd_data),
    .data_ready(data_ready), .brk_flag(brk_flag), .overrun(overrun),
    .fifo_count(fifo_count), .trig_hit(trig_hit), .tmo_pend(tmo_pend)
  );

  // ---------------- reference model ----------------
  logic [7:0] q[$];
  bit   m_en, m_dr, m_brk, m_ovr, m_pend, m_run;
  int   m_lvl, m_tcnt;
  logic [7:0] m_hold;

  function automatic int lvl_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    if (code == 2) return 8;
    return 14;
  endfunction

  function automatic int char_ticks(input logic [3:0] f);
    int bits;
    bits = 2 + 5 + f[1:0];
    if (f[3]) bits++;
    if (f[2]) bits++;
    return bits;
  endfunction

  always @(posedge clk) begin : model
    bit fl, rxa, expn, rst_t;
    logic [7:0] b;
    if (!rst_n) begin
      q.delete(); m_en = 0; m_dr = 0; m_brk = 0; m_ovr = 0; m_pend = 0;
      m_run = 0; m_tcnt = 0; m_lvl = 0; m_hold = 8'h00;
    end else begin
      fl    = fcr_we && (fcr_wdata[1] || (fcr_wdata[0] != m_en));
      rxa   = (rx_valid || rx_break) && !fl;
      b     = rx_break ? 8'h00 : rx_byte;
      rst_t = 0; expn = 0;
      if (stat_rd) begin m_ovr = 0; m_brk = 0; end
      if (fl) begin
        q.delete(); m_dr = 0; m_brk = 0; m_pend = 0; m_run = 0;
      end else begin
        if (m_en) begin
          if (rd_stb) begin
            if (q.size() > 0) void'(q.pop_front());
            if (q.size() == 0) begin m_dr = 0; m_brk = 0; end
            else rst_t = 1;
          end
          if (rxa) begin
            if (q.size() < DEPTH) q.push_back(b);
            else m_ovr = 1;
            m_dr = 1;
            if (rx_break) m_brk = 1;
            rst_t = 1;
          end
        end else begin
          if (rd_stb) begin m_dr = 0; m_brk = 0; end
          if (rxa) begin
            if (m_dr) m_ovr = 1;
            m_hold = b; m_dr = 1;
            if (rx_break) m_brk = 1;
          end
        end
        if (rst_t) begin m_run = 1; m_tcnt = 4 * char_ticks(lcr_fmt); end
        else if (m_run && baud_tick) begin
          if (m_tcnt == 1) begin m_run = 0; expn = 1; end
          else m_tcnt--;
        end
        if (expn && q.size() != 0) m_pend = 1;
        else if (rd_stb) m_pend = 0;
      end
      if (fcr_we) begin m_en = fcr_wdata[0]; m_lvl = fcr_wdata[7:6]; end
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h t=%0t", req, phase, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R4", "rd_data", rd_data, m_en ? (q.size() > 0 ? q[0] : 0) : m_hold);
      chk("R4", "data_ready", data_ready, m_dr);
      chk("R7", "brk_flag", brk_flag, m_brk);
      chk("R5", "overrun", overrun, m_ovr);
      chk("R4", "fifo_count", fifo_count, q.size());
      chk("R2", "trig_hit", trig_hit, m_en ? (q.size() >= lvl_of(m_lvl)) : m_dr);
      chk("R9", "tmo_pend", tmo_pend, m_pend);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drv(input bit rv, input logic [7:0] rb, input bit bk, input bit fw,
                     input logic [7:0] fd, input bit rd, input bit st);
    @(negedge clk);
    rx_valid = rv; rx_byte = rb; rx_break = bk; fcr_we = fw; fcr_wdata = fd;
    rd_stb = rd; stat_rd = st;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 8'h00, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic rx(input logic [7:0] b);   drv(1, b, 0, 0, 8'h00, 0, 0); endtask
  task automatic rd();                      drv(0, 8'h00, 0, 0, 8'h00, 1, 0); endtask
  task automatic fcr(input logic [7:0] v);  drv(0, 8'h00, 0, 1, v, 0, 0); endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset_dr", data_ready, 0);
    chk("R1", "reset_count", fifo_count, 0);
    chk("R1", "reset_flags", {brk_flag, overrun, trig_hit, tmo_pend}, 0);
    chk("R1", "reset_rd_data", rd_data, 0);

    phase = "R6";
    rx(8'hA5); idle(2); rd(); idle(1);
    rx(8'h11); rx(8'h22); idle(2);
    drv(1, 8'h33, 0, 0, 8'h00, 1, 0); idle(1);   // read and receive together: no overrun from old ready
    phase = "R8";
    drv(0, 8'h00, 0, 0, 8'h00, 0, 1); idle(1);
    rx(8'h44); drv(1, 8'h55, 0, 0, 8'h00, 0, 1); idle(2);
    rd(); idle(1);

    phase = "R2";
    fcr(8'h41); idle(1);
    for (int i = 1; i <= 5; i++) rx(8'(i));
    idle(2);
    phase = "R4";
    for (int i = 0; i < 6; i++) rd();
    idle(2);
    phase = "R2";
    fcr(8'h81);
    for (int i = 0; i < 9; i++) rx(8'(8'h60 + i));
    fcr(8'hC1); idle(1);
    for (int i = 0; i < 5; i++) rx(8'(8'h70 + i));
    idle(1);

    phase = "R5";
    for (int i = 0; i < 4; i++) rx(8'(8'h80 + i));
    drv(1, 8'hEE, 0, 0, 8'h00, 1, 0);
    rx(8'hEF); idle(1);
    drv(0, 8'h00, 0, 0, 8'h00, 0, 1); idle(1);

    phase = "R3";
    drv(1, 8'h99, 0, 1, 8'hC3, 1, 0); idle(2);
    fcr(8'hC0); idle(1); rx(8'h12); fcr(8'h01); idle(1);

    phase = "R7";
    drv(0, 8'h00, 1, 0, 8'h00, 0, 0);
    drv(1, 8'h5A, 1, 0, 8'h00, 0, 0);
    rx(8'h77); idle(1);
    rd(); rd(); idle(1); rd(); idle(1);
    drv(0, 8'h00, 1, 0, 8'h00, 0, 0); drv(0, 8'h00, 0, 0, 8'h00, 0, 1); rd(); idle(1);

    phase = "R10";
    foreach (lcr_fmt_list[k]) begin
      lcr_fmt = lcr_fmt_list[k];
      rx(8'hC0); rx(8'hC1); rx(8'hC2);
      idle(110);
      rd(); idle(110);
      rd(); rd(); idle(110);
    end

    phase = "R11";
    lcr_fmt = 4'h3;
    rx(8'hD0); idle(40); fcr(8'h03); idle(110);
    rx(8'hD1); idle(100); fcr(8'h00); idle(10);
    fcr(8'h01); rx(8'hD2); idle(100); fcr(8'h00); idle(5); rd(); idle(2);

    phase = "R9";
    fcr(8'h41);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] v;
      bit fw;
      fw = ($urandom % 97) == 0;
      v  = 8'($urandom);
      if (fw && ($urandom % 4) != 0) v[0] = 1'b1;
      if (($urandom % 211) == 0) lcr_fmt = 4'($urandom);
      drv(($urandom % 3) == 0, 8'($urandom), ($urandom % 40) == 0, fw, v,
          ($urandom % 5) == 0, ($urandom % 13) == 0);
      if (($urandom % 300) == 0) idle(100);
    end
    idle(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [3:0] lcr_fmt_list [4] = '{4'h0, 4'h3, 4'hF, 4'h8};
endmodule